// File: doc/BRIEF.md
# Comparator-Mode Controller for a Successive-Approximation A-D Peripheral

This block is the digital side of the threshold-compare mode of a small microcontroller's A-D peripheral. A 4-bit control register holds a mode bit. When that bit is set, the peripheral stops converting and acts as a single-threshold comparator. The CPU builds an 8-bit threshold from its two 4-bit accumulators and can read the threshold back into them. A start strobe opens a fixed compare window. During the window the threshold drives the on-chip DAC and the analog comparator output is sampled at the close of the window.

The outcome is stored in a sticky "input below threshold" flag. Software consumes it in one of two ways: an interrupt request, when the interrupt-enable input is high, or a skip-on-flag test. Either way of consuming it clears the flag. The threshold register is kept apart from the conversion result register. A separate transfer command copies the two least significant result bits into the upper half of accumulator A. The analog DAC and comparator are not part of this block. They are represented by the `dac_code`/`dac_en` outputs and the `cmp_in` input.

Top module: `cmpmode_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the control register, threshold, conversion result, flag, window counter and `dac_en`. After reset `cmp_mode`=0, `dac_code`=0, `adf`=0 and both accumulator write strobes are 0.
- R2: A `ctl_wr` cycle loads `ctl_din` into `ctl_q` on the next edge. `cmp_mode` follows bit 3 of the stored value: 1 selects comparator mode and 0 selects conversion mode.
- R3: In comparator mode, `load_thr` sets the threshold to {`acc_b`,`acc_a`}, with B as the high nibble. The new value is on `dac_code` the cycle after. In conversion mode `load_thr` leaves the threshold unchanged.
- R4: In comparator mode, `read_thr` makes the following cycle show `acc_we_a`=1 with `acc_wd_a`=threshold[3:0] and `acc_we_b`=1 with `acc_wd_b`=threshold[7:4]. In conversion mode `read_thr` raises neither strobe.
- R5: The threshold keeps its value across a change from comparator mode to conversion mode and back.
- R6: A `start` pulse in comparator mode raises `dac_en` from the next cycle for exactly 8 cycles. A `start` in conversion mode does nothing.
- R7: At the edge that closes the window, `adf` is set to 1 if `cmp_in`=1 (input below threshold). If `cmp_in`=0, `adf` keeps its value.
- R8: A `start` while the window is open is ignored. The window still closes 8 cycles after the original start.
- R9: `irq_ack` or `skip_test` clears `adf` on the next edge. While `skip_test` is high, `skip_hit` shows the current flag.
- R10: `irq_req` is 1 only while `adf`=1 and `irq_en`=1. With `irq_en`=0 a set flag stays set until it is consumed.
- R11: In conversion mode, `conv_wr` stores `conv_din` as the conversion result on `conv_res`. `xfer_conv` makes the next cycle show `acc_we_a`=1 and `acc_wd_a`={result[1:0],2'b00}, with `acc_we_b`=0.
- R12: A control write that clears the mode bit during an open window closes it at that edge. `dac_en` is 0 the cycle after, and `adf` is not set.
- R13: If the window closes with `cmp_in`=1 in the same cycle as `irq_ack` or `skip_test`, `adf` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_din | input | 4 | Control value; bit 3 is the mode bit |
| acc_a | input | 4 | Accumulator A contents (low threshold nibble) |
| acc_b | input | 4 | Accumulator B contents (high threshold nibble) |
| load_thr | input | 1 | Load threshold from B:A |
| read_thr | input | 1 | Copy threshold back into B:A |
| xfer_conv | input | 1 | Move result bits 1:0 into A[3:2] |
| conv_wr | input | 1 | Store a new conversion result |
| conv_din | input | 8 | Conversion result from the SAR path |
| start | input | 1 | Open a compare window |
| cmp_in | input | 1 | Analog comparator output, 1 = input below DAC level |
| irq_en | input | 1 | 1 = flag raises an interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| skip_test | input | 1 | Skip-on-flag test, consumes the flag |
| ctl_q | output | 4 | Stored control register |
| cmp_mode | output | 1 | 1 while comparator mode is selected |
| conv_res | output | 8 | Stored conversion result |
| dac_code | output | 8 | Threshold code n, level n/256 of full scale |
| dac_en | output | 1 | DAC/comparator enable during the window |
| adf | output | 1 | Input-below-threshold flag |
| irq_req | output | 1 | Interrupt request |
| skip_hit | output | 1 | Skip-test result |
| acc_we_a | output | 1 | Write strobe for accumulator A |
| acc_wd_a | output | 4 | Write data for accumulator A |
| acc_we_b | output | 1 | Write strobe for accumulator B |
| acc_wd_b | output | 4 | Write data for accumulator B |

## Verification
The bench counts enable cycles for each window. A counter that is off by one would show 7 or 9, and a second start that restarted the counter would stretch the window past 8. Threshold loads and reads are issued in conversion mode, where a design that ignored the mode bit would overwrite or read back the threshold. The threshold is also followed across a round trip through conversion mode, which catches a design that shares it with the result. A mode drop in the middle of a window checks that a truncated compare never sets the flag. A clear that coincides with the closing edge checks that the new result is not lost. The table of thresholds, comparator levels and consume paths exercises the sticky flag and both ways of clearing it.

// File: rtl/cmpmode_pkg.sv
package cmpmode_pkg;

    localparam int NIB_W    = 4;
    localparam int CODE_W   = 2 * NIB_W;
    localparam int CTL_W    = 4;
    localparam int MODE_BIT = 3;
    localparam int XFER_W   = 2;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CTL_W-1:0]  ctl_t;

    typedef struct packed {
        logic we_a;
        nib_t wd_a;
        logic we_b;
        nib_t wd_b;
    } acc_wr_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic code_t join_nibs(input nib_t hi, input nib_t lo);
        return {hi, lo};
    endfunction

    // Result bits land in the top of the nibble; the rest are zero.
    function automatic nib_t xfer_nib(input logic [XFER_W-1:0] res_lo);
        nib_t n;
        n = '0;
        n[NIB_W-1 -: XFER_W] = res_lo;
        return n;
    endfunction

endpackage

// File: rtl/cmp_cfg_regs.sv
module cmp_cfg_regs
    import cmpmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctl_wr,
    input  ctl_t  ctl_din,
    input  logic  load_thr,
    input  nib_t  acc_a,
    input  nib_t  acc_b,
    input  logic  conv_wr,
    input  code_t conv_din,
    output ctl_t  ctl_q,
    output logic  cmp_mode,
    output logic  mode_nxt,
    output code_t thr_q,
    output code_t conv_q
);

    ctl_t ctl_nxt;

    always_comb begin
        ctl_nxt  = ctl_wr ? ctl_din : ctl_q;
        mode_nxt = ctl_nxt[MODE_BIT];
    end

    assign cmp_mode = ctl_q[MODE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            thr_q  <= '0;
            conv_q <= '0;
        end else begin
            ctl_q <= ctl_nxt;
            // threshold is only reachable in comparator mode
            if (load_thr && cmp_mode) begin
                thr_q <= join_nibs(acc_b, acc_a);
            end
            // result is owned by the conversion path
            if (conv_wr && !cmp_mode) begin
                conv_q <= conv_din;
            end
        end
    end

endmodule

// File: rtl/cmp_window_seq.sv
module cmp_window_seq
    import cmpmode_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cmp_mode,
    input  logic mode_nxt,
    input  logic cmp_in,
    output logic dac_en,
    output logic set_evt
);

    localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

    seq_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (st_q == SEQ_RUN) && (cnt_q == LAST);
    assign dac_en  = (st_q == SEQ_RUN);
    // comparator is sampled on the closing edge of a window that survives
    assign set_evt = at_last && mode_nxt && cmp_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (start && cmp_mode && mode_nxt) begin
                        st_q <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (!mode_nxt || at_last) begin
                        st_q  <= SEQ_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= SEQ_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic irq_ack,
    input  logic skip_test,
    input  logic irq_en,
    output logic adf,
    output logic irq_req,
    output logic skip_hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            adf <= 1'b0;
        end else if (set_evt) begin
            adf <= 1'b1;
        end else if (irq_ack || skip_test) begin
            adf <= 1'b0;
        end
    end

    assign irq_req  = adf && irq_en;
    assign skip_hit = adf && skip_test;

endmodule

// File: rtl/cmp_acc_port.sv
module cmp_acc_port
    import cmpmode_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               read_thr,
    input  logic               xfer_conv,
    input  logic               cmp_mode,
    input  code_t              thr_q,
    input  logic [XFER_W-1:0]  res_lo,
    output acc_wr_t            acc_wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_wr <= '0;
        end else begin
            acc_wr <= '0;
            if (read_thr && cmp_mode) begin
                acc_wr.we_a <= 1'b1;
                acc_wr.wd_a <= thr_q[NIB_W-1:0];
                acc_wr.we_b <= 1'b1;
                acc_wr.wd_b <= thr_q[CODE_W-1:NIB_W];
            end else if (xfer_conv) begin
                acc_wr.we_a <= 1'b1;
                acc_wr.wd_a <= xfer_nib(res_lo);
            end
        end
    end

endmodule

// File: rtl/cmpmode_ctrl.sv
module cmpmode_ctrl
    import cmpmode_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_din,
    input  logic [NIB_W-1:0]  acc_a,
    input  logic [NIB_W-1:0]  acc_b,
    input  logic              load_thr,
    input  logic              read_thr,
    input  logic              xfer_conv,
    input  logic              conv_wr,
    input  logic [CODE_W-1:0] conv_din,
    input  logic              start,
    input  logic              cmp_in,
    input  logic              irq_en,
    input  logic              irq_ack,
    input  logic              skip_test,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              cmp_mode,
    output logic [CODE_W-1:0] conv_res,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_en,
    output logic              adf,
    output logic              irq_req,
    output logic              skip_hit,
    output logic              acc_we_a,
    output logic [NIB_W-1:0]  acc_wd_a,
    output logic              acc_we_b,
    output logic [NIB_W-1:0]  acc_wd_b
);

    logic    mode_nxt;
    code_t   thr_q;
    logic    set_evt;
    acc_wr_t acc_wr;

    cmp_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_din  (ctl_din),
        .load_thr (load_thr),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .conv_wr  (conv_wr),
        .conv_din (conv_din),
        .ctl_q    (ctl_q),
        .cmp_mode (cmp_mode),
        .mode_nxt (mode_nxt),
        .thr_q    (thr_q),
        .conv_q   (conv_res)
    );

    cmp_window_seq #(
        .WIN_CYC (WIN_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmp_mode (cmp_mode),
        .mode_nxt (mode_nxt),
        .cmp_in   (cmp_in),
        .dac_en   (dac_en),
        .set_evt  (set_evt)
    );

    cmp_flag_unit u_flag (
        .clk       (clk),
        .rst       (rst),
        .set_evt   (set_evt),
        .irq_ack   (irq_ack),
        .skip_test (skip_test),
        .irq_en    (irq_en),
        .adf       (adf),
        .irq_req   (irq_req),
        .skip_hit  (skip_hit)
    );

    cmp_acc_port u_acc (
        .clk       (clk),
        .rst       (rst),
        .read_thr  (read_thr),
        .xfer_conv (xfer_conv),
        .cmp_mode  (cmp_mode),
        .thr_q     (thr_q),
        .res_lo    (conv_res[XFER_W-1:0]),
        .acc_wr    (acc_wr)
    );

    assign dac_code = thr_q;
    assign acc_we_a = acc_wr.we_a;
    assign acc_wd_a = acc_wr.wd_a;
    assign acc_we_b = acc_wr.we_b;
    assign acc_wd_b = acc_wr.wd_b;

endmodule

// File: rtl/cmpmode_chk.sv
module cmpmode_chk
    import cmpmode_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              cmp_mode,
    input logic              load_thr,
    input logic [NIB_W-1:0]  acc_a,
    input logic [NIB_W-1:0]  acc_b,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_en,
    input logic              adf,
    input logic              irq_ack,
    input logic              skip_test
);

    localparam int RUN_W = $clog2(WIN_CYC + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (dac_en) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dac_en && !adf && !cmp_mode));

    // R3
    thr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_thr && cmp_mode) |=> (dac_code == $past({acc_b, acc_a})));

    // R3
    thr_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (load_thr && !cmp_mode) |=> $stable(dac_code));

    // R6
    win_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_en) |-> ($past(start) && $past(cmp_mode)));

    // R8
    win_no_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        dac_en |-> (run_q < RUN_W'(WIN_CYC)));

    // R6
    win_full_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(dac_en) && cmp_mode) |-> (run_q == RUN_W'(WIN_CYC)));

    // R7
    flag_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(adf) |-> ($past(dac_en) && !dac_en));

    // R9
    flag_consume_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_ack || skip_test) && !dac_en) |=> !adf);

endmodule

bind cmpmode_ctrl cmpmode_chk #(
    .WIN_CYC (WIN_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmp_mode  (cmp_mode),
    .load_thr  (load_thr),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .dac_code  (dac_code),
    .dac_en    (dac_en),
    .adf       (adf),
    .irq_ack   (irq_ack),
    .skip_test (skip_test)
);

// File: tb/tb_cmpmode_ctrl.sv
module tb_cmpmode_ctrl;

    localparam int CLK_PER = 10;
    localparam int WIN     = 8;
    localparam int NVEC    = 6;

    // {threshold[7:0], cmp_in, irq_en, consume_by_ack, expected_flag}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h80, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'h5A, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h01, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'hC3, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_din = '0;
    logic [3:0] acc_a = '0;
    logic [3:0] acc_b = '0;
    logic       load_thr = 1'b0;
    logic       read_thr = 1'b0;
    logic       xfer_conv = 1'b0;
    logic       conv_wr = 1'b0;
    logic [7:0] conv_din = '0;
    logic       start = 1'b0;
    logic       cmp_in = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       skip_test = 1'b0;
    logic [3:0] ctl_q;
    logic       cmp_mode;
    logic [7:0] conv_res;
    logic [7:0] dac_code;
    logic       dac_en;
    logic       adf;
    logic       irq_req;
    logic       skip_hit;
    logic       acc_we_a;
    logic [3:0] acc_wd_a;
    logic       acc_we_b;
    logic [3:0] acc_wd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    cmpmode_ctrl #(.WIN_CYC(WIN)) dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
        .acc_a(acc_a), .acc_b(acc_b), .load_thr(load_thr), .read_thr(read_thr),
        .xfer_conv(xfer_conv), .conv_wr(conv_wr), .conv_din(conv_din),
        .start(start), .cmp_in(cmp_in), .irq_en(irq_en), .irq_ack(irq_ack),
        .skip_test(skip_test), .ctl_q(ctl_q), .cmp_mode(cmp_mode),
        .conv_res(conv_res), .dac_code(dac_code), .dac_en(dac_en), .adf(adf),
        .irq_req(irq_req), .skip_hit(skip_hit), .acc_we_a(acc_we_a),
        .acc_wd_a(acc_wd_a), .acc_we_b(acc_we_b), .acc_wd_b(acc_wd_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        ctl_wr  = 1'b1;
        ctl_din = {m, 3'b010};
        tick();
        ctl_wr  = 1'b0;
    endtask

    task automatic load(input logic [7:0] v);
        acc_b    = v[7:4];
        acc_a    = v[3:0];
        load_thr = 1'b1;
        tick();
        load_thr = 1'b0;
    endtask

    task automatic run_window(input logic cin, output int n);
        cmp_in = cin;
        start  = 1'b1;
        tick();
        start  = 1'b0;
        n = 0;
        while (dac_en && n < 40) begin
            n++;
            tick();
        end
    endtask

    task automatic consume_skip();
        skip_test = 1'b1;
        tick();
        skip_test = 1'b0;
    endtask

    initial begin
        #(CLK_PER * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 cmp_mode after reset", cmp_mode, 0);
        chk("R1 dac_code after reset", dac_code, 0);
        chk("R1 adf after reset", adf, 0);
        chk("R1 dac_en after reset", dac_en, 0);
        chk("R1 acc strobes after reset", {acc_we_a, acc_we_b}, 0);

        // conversion mode: start ignored, load ignored
        start = 1'b1; tick(); start = 1'b0;
        chk("R6 start in conversion mode", dac_en, 0);
        load(8'h77);
        chk("R3 load ignored in conversion mode", dac_code, 8'h00);

        // R11 transfer path
        conv_din = 8'h37; conv_wr = 1'b1; tick(); conv_wr = 1'b0;
        chk("R11 conversion result stored", conv_res, 8'h37);
        xfer_conv = 1'b1; tick(); xfer_conv = 1'b0;
        chk("R11 transfer strobe A", acc_we_a, 1);
        chk("R11 transfer data A", acc_wd_a, 4'hC);
        chk("R11 transfer leaves B", acc_we_b, 0);
        read_thr = 1'b1; tick(); read_thr = 1'b0;
        chk("R4 read ignored in conversion mode", {acc_we_a, acc_we_b}, 0);

        set_mode(1'b1);
        chk("R2 mode bit set", cmp_mode, 1);
        chk("R2 control value stored", ctl_q, 4'hA);

        load(8'h3C);
        chk("R3 threshold loaded B:A", dac_code, 8'h3C);
        read_thr = 1'b1; tick(); read_thr = 1'b0;
        chk("R4 read strobes", {acc_we_a, acc_we_b}, 2'b11);
        chk("R4 read data A low nibble", acc_wd_a, 4'hC);
        chk("R4 read data B high nibble", acc_wd_b, 4'h3);

        set_mode(1'b0);
        chk("R2 mode bit cleared", cmp_mode, 0);
        load(8'h99);
        chk("R5 threshold kept in conversion mode", dac_code, 8'h3C);
        set_mode(1'b1);
        chk("R5 threshold kept after return", dac_code, 8'h3C);

        // table of windows
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[i];
            irq_en = v[2];
            load(v[11:4]);
            run_window(v[3], n);
            chk($sformatf("R6 window length vec%0d", i), n, WIN);
            chk($sformatf("R7 flag after window vec%0d", i), adf, v[0]);
            chk($sformatf("R10 irq request vec%0d", i), irq_req, v[0] & v[2]);
            if (v[1]) begin
                irq_ack = 1'b1; tick(); irq_ack = 1'b0;
            end else begin
                skip_test = 1'b1;
                #1;
                chk($sformatf("R9 skip result vec%0d", i), skip_hit, v[0]);
                tick();
                skip_test = 1'b0;
            end
            chk($sformatf("R9 flag consumed vec%0d", i), adf, 0);
        end

        // R7 sticky: a low compare leaves a set flag alone; R10 no irq when disabled
        irq_en = 1'b0;
        run_window(1'b1, n);
        run_window(1'b0, n);
        chk("R7 flag kept on low compare", adf, 1);
        chk("R10 no request with irq disabled", irq_req, 0);
        tick(); tick();
        chk("R10 flag waits for consume", adf, 1);
        consume_skip();
        chk("R9 skip clears flag", adf, 0);

        // R8 restart during a window is ignored
        cmp_in = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        n = 0;
        while (dac_en && n < 40) begin
            n++;
            start = (n == 3 || n == 7);
            tick();
        end
        start = 1'b0;
        chk("R8 window not restarted", n, WIN);
        consume_skip();

        // R12 abort by mode change
        cmp_in = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        tick(); tick();
        chk("R12 window open before abort", dac_en, 1);
        set_mode(1'b0);
        chk("R12 enable dropped on mode exit", dac_en, 0);
        tick(); tick(); tick(); tick(); tick(); tick(); tick();
        chk("R12 no flag from aborted window", adf, 0);
        set_mode(1'b1);

        // R13 set wins over a same-edge clear
        cmp_in = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        repeat (WIN - 1) tick();
        chk("R13 window still open on last cycle", dac_en, 1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R13 window closed", dac_en, 0);
        chk("R13 flag set despite acknowledge", adf, 1);
        consume_skip();
        chk("R9 cleared after collision", adf, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule